// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Arbiter

This block shares one single-ported memory between several masters (two by default) and lets a master perform an atomic read-modify-write. When no lock is held, requests are granted in round-robin order. A read that carries the lock flag makes its issuer the lock owner. From then on only the owner is served, until it sends the write that completes the pair. Every other master is held off, so no one else can touch the target word in between.

The atomic sequence can fail. If the owner's instruction faults after the locked read, the core raises an abort and the lock is dropped on the next cycle. If the closing write names a different address, the write is refused with an error response and the lock is dropped. If neither happens within a configurable number of cycles, a watchdog frees the bus and sets a sticky error flag. In every case a locked read with no matching write cannot leave the memory port stuck. An atomic-busy output tells the interrupt logic to hold off interrupts while a sequence is open.

Top module: `rmw_bus_arb`

## Requirements
- R1: After a synchronous active-low reset, no lock is held, `atomic_busy`, `lock_timeout_err`, `rsp_valid` and `rsp_err` are all zero, and the round-robin pointer favours master 0.
- R2: At most one request is accepted per cycle (`req_ready` is one-hot or zero). An accepted request drives the memory port in the same cycle. The issuing master sees `rsp_valid` one cycle later, with `rsp_rdata` holding the memory word for a read.
- R3: With no lock held and several masters valid, the grant goes to the next valid master after the one most recently granted, wrapping around. A single valid master is always granted.
- R4: An accepted read with `req_lock`=1 starts a lock. From the next cycle, `atomic_busy` is 1 and only the owner can be granted; every other master sees `req_ready`=0.
- R5: While a lock is held, an owner write to the locked address is performed, returns `rsp_err`=0, and releases the lock, so `atomic_busy` is 0 from the following cycle. Owner reads during the lock are served and do not release it.
- R6: While a lock is held, an owner write to any other address makes no memory access (`mem_en`=0), returns `rsp_err`=1 one cycle later, and releases the lock.
- R7: `req_abort` from the owner while a lock is held releases the lock on the next cycle, and the owner's request in that cycle is not accepted. `req_abort` has no effect when no lock is held or when it comes from a master that does not own the lock.
- R8: A lock still held after TIMEOUT cycles (default 256) with no release is forced free, and `lock_timeout_err` rises and stays at 1 until reset.
- R9: A write carrying `req_lock`=1 while no lock is held is an ordinary write and does not start a lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NM | Request valid per master |
| req_ready | output | NM | Request accepted this cycle, per master |
| req_addr | input | NM*AW | Word address per master, master 0 in the low slice |
| req_we | input | NM | 1 = write, 0 = read |
| req_wdata | input | NM*DW | Write data per master |
| req_lock | input | NM | Read starts an atomic lock |
| req_abort | input | NM | Core faulted its atomic instruction; release the lock |
| rsp_valid | output | NM | Response for the request accepted one cycle earlier |
| rsp_err | output | NM | Response carries an error (mismatched closing write) |
| rsp_rdata | output | DW | Read data for the response |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after the strobe |
| atomic_busy | output | 1 | Atomic sequence open; used as an interrupt mask |
| lock_timeout_err | output | 1 | Sticky: a lock was forced free by the watchdog |

## Verification
The assertions assume that the memory returns read data exactly one cycle after `mem_en`, and that request inputs are known whenever reset is high. They do not assume that masters hold `req_valid` stable until `req_ready`, so the stimulus may freely drop or change a request between cycles and the reference model follows each cycle as driven. The stimulus drives aborts from both owning and non-owning masters and with no lock held, to cover the cases that must be ignored. It also keeps a rival master requesting the locked word for the whole lock window and past the watchdog expiry.

// File: rtl/rmw_arb_pkg.sv
// Package: shared types for the locked read-modify-write arbiter.
// Assumes: nothing; types only.
package rmw_arb_pkg;
    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;
endpackage

// File: rtl/rmw_rr_pick.sv
// Module: round-robin picker. Searches the request vector starting one
// place after the last granted index and grants the first set bit.
// Assumes: NM >= 2; purely combinational.
module rmw_rr_pick #(
    parameter int NM = 2,
    parameter int IW = 1
) (
    input  logic [NM-1:0] req,
    input  logic [IW-1:0] last,
    output logic [NM-1:0] gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    int cand;

    // Scan the masters in rotated order and take the first requester.
    always_comb begin
        gnt  = '0;
        idx  = '0;
        any  = 1'b0;
        cand = 0;
        for (int k = 1; k <= NM; k++) begin
            cand = (int'(last) + k) % NM;
            if (!any && req[cand]) begin
                any       = 1'b1;
                gnt[cand] = 1'b1;
                idx       = IW'(cand);
            end
        end
    end
endmodule

// File: rtl/rmw_lock_ctrl.sv
// Module: lock state machine. Opens a lock on an accepted locked read and
// closes it on the owner's write, on an owner abort, or when the watchdog
// expires (which also sets a sticky error).
// Assumes: acc_* describe the single request accepted this cycle.
module rmw_lock_ctrl
    import rmw_arb_pkg::*;
#(
    parameter int NM      = 2,
    parameter int IW      = 1,
    parameter int AW      = 8,
    parameter int TIMEOUT = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic [IW-1:0] acc_idx,
    input  logic          acc_we,
    input  logic          acc_lock,
    input  logic [AW-1:0] acc_addr,
    input  logic [NM-1:0] abort,
    output logic          held,
    output logic [IW-1:0] owner,
    output logic [AW-1:0] lock_addr,
    output logic          timeout_err
);
    localparam int CW = $clog2(TIMEOUT + 1);

    lock_state_e   state;
    logic [CW-1:0] age;
    logic          open_lk, pair_wr, abort_hit, expire;

    assign held = (state == LK_HELD);

    // Decode the events that open or close the lock this cycle.
    always_comb begin
        open_lk   = !held && acc && acc_lock && !acc_we;
        pair_wr   = held && acc && acc_we;
        abort_hit = held && abort[owner];
        expire    = held && !pair_wr && !abort_hit && (age == CW'(TIMEOUT - 1));
    end

    // Lock state, owner, locked address and age counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= LK_FREE;
            owner     <= '0;
            lock_addr <= '0;
            age       <= '0;
        end else if (open_lk) begin
            state     <= LK_HELD;
            owner     <= acc_idx;
            lock_addr <= acc_addr;
            age       <= '0;
        end else if (pair_wr || abort_hit || expire) begin
            state <= LK_FREE;
            age   <= '0;
        end else if (held) begin
            age <= age + 1'b1;
        end
    end

    // Sticky watchdog error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      timeout_err <= 1'b0;
        else if (expire) timeout_err <= 1'b1;
    end

    a_r7_abort_frees: assert property (@(posedge clk) disable iff (!rst_n)
        held && abort[owner] |=> !held);
    a_r8_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
        held && (age == CW'(TIMEOUT - 1)) |=> !held);
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err);
    a_r4_owner_stable: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> (!held || owner == $past(owner)));
endmodule

// File: rtl/rmw_rsp_stage.sv
// Module: response register. Returns a valid strobe (and error) to the
// master whose request was accepted one cycle earlier.
// Assumes: grant vector is one-hot or zero.
module rmw_rsp_stage #(
    parameter int NM = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] gnt,
    input  logic          reject,
    output logic [NM-1:0] rsp_valid,
    output logic [NM-1:0] rsp_err
);
    // Register the grant as the response strobe, with the reject flag as error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_err   <= '0;
        end else begin
            rsp_valid <= gnt;
            rsp_err   <= reject ? gnt : '0;
        end
    end
endmodule

// File: rtl/rmw_bus_arb.sv
// Module: top of the locked read-modify-write arbiter. Shares one memory
// port among NM masters, round-robin when free, owner-only while locked.
// Assumes: memory returns read data one cycle after mem_en; NM >= 2.
module rmw_bus_arb
    import rmw_arb_pkg::*;
#(
    parameter int NM      = 2,
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int TIMEOUT = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NM-1:0]    req_valid,
    output logic [NM-1:0]    req_ready,
    input  logic [NM*AW-1:0] req_addr,
    input  logic [NM-1:0]    req_we,
    input  logic [NM*DW-1:0] req_wdata,
    input  logic [NM-1:0]    req_lock,
    input  logic [NM-1:0]    req_abort,
    output logic [NM-1:0]    rsp_valid,
    output logic [NM-1:0]    rsp_err,
    output logic [DW-1:0]    rsp_rdata,
    output logic             mem_en,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             atomic_busy,
    output logic             lock_timeout_err
);
    localparam int IW = $clog2(NM);

    logic [AW-1:0] addr_a [NM];
    logic [DW-1:0] data_a [NM];
    logic [NM-1:0] elig, gnt, owner_oh;
    logic [IW-1:0] idx, last, owner;
    logic [AW-1:0] lock_addr, acc_addr;
    logic          any, held, acc_we, acc_lock, reject;

    // Slice the flattened request buses per master.
    for (genvar g = 0; g < NM; g++) begin : g_unpack
        assign addr_a[g] = req_addr[g*AW +: AW];
        assign data_a[g] = req_wdata[g*DW +: DW];
    end

    // Eligible requesters: everyone when free, only a non-aborting owner when held.
    always_comb begin
        owner_oh = NM'(1) << owner;
        elig     = held ? (req_valid & ~req_abort & owner_oh) : req_valid;
    end

    rmw_rr_pick #(.NM(NM), .IW(IW)) u_pick (
        .req  (elig),
        .last (last),
        .gnt  (gnt),
        .idx  (idx),
        .any  (any)
    );

    // Round-robin pointer: remembers the last accepted master.
    always_ff @(posedge clk) begin
        if (!rst_n)   last <= IW'(NM - 1);
        else if (any) last <= idx;
    end

    // Select the accepted request and screen a mismatched closing write.
    always_comb begin
        acc_we   = req_we[idx];
        acc_lock = req_lock[idx];
        acc_addr = addr_a[idx];
        reject   = held && any && acc_we && (acc_addr != lock_addr);
    end

    assign req_ready = gnt;
    assign mem_en    = any && !reject;
    assign mem_we    = acc_we;
    assign mem_addr  = acc_addr;
    assign mem_wdata = data_a[idx];
    assign rsp_rdata = mem_rdata;

    rmw_lock_ctrl #(.NM(NM), .IW(IW), .AW(AW), .TIMEOUT(TIMEOUT)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc         (any),
        .acc_idx     (idx),
        .acc_we      (acc_we),
        .acc_lock    (acc_lock),
        .acc_addr    (acc_addr),
        .abort       (req_abort),
        .held        (held),
        .owner       (owner),
        .lock_addr   (lock_addr),
        .timeout_err (lock_timeout_err)
    );

    rmw_rsp_stage #(.NM(NM)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt       (gnt),
        .reject    (reject),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err)
    );

    assign atomic_busy = held;

    a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready != '0) |=> (rsp_valid == $past(req_ready)));
    a_r4_others_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        atomic_busy |-> ((req_ready & ~owner_oh) == '0));
    a_r6_locked_addr_guard: assert property (@(posedge clk) disable iff (!rst_n)
        atomic_busy && mem_en && mem_we |-> (mem_addr == lock_addr));
endmodule

// File: tb/rmw_bus_arb_tb.sv
`timescale 1ns/1ps
module rmw_bus_arb_tb_top;
    localparam int TMO = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  v = '0, we = '0, lk = '0, ab = '0;
    logic [7:0]  a0 = '0, a1 = '0;
    logic [31:0] d0 = '0, d1 = '0;
    logic [1:0]  req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
    logic        mem_en, mem_we, atomic_busy, lock_timeout_err;
    logic [7:0]  mem_addr;

    int checks = 0;
    int fails  = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    rmw_bus_arb #(.NM(2), .AW(8), .DW(32), .TIMEOUT(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(v), .req_ready(req_ready),
        .req_addr({a1, a0}), .req_we(we), .req_wdata({d1, d0}),
        .req_lock(lk), .req_abort(ab),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .atomic_busy(atomic_busy), .lock_timeout_err(lock_timeout_err)
    );

    // Bench memory driven by the DUT port, plus an independent shadow.
    logic [31:0] mem  [256];
    logic [31:0] mmem [256];
    initial for (int i = 0; i < 256; i++) begin
        mem[i]  = 32'h1000 + i * 3;
        mmem[i] = 32'h1000 + i * 3;
    end
    always @(posedge clk) if (mem_en) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        else        mem_rdata     <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // Reference model state.
    bit          mvalid = 0, m_lk = 0, m_terr = 0, e_rd = 0;
    int          m_own = 0, m_last = 1, m_cnt = 0;
    logic [7:0]  m_laddr = '0;
    logic [1:0]  e_rv = '0, e_re = '0;
    logic [31:0] e_rdata = '0;

    // Compare at the falling edge, then advance the model as the next rising edge will.
    always @(negedge clk) begin
        if (!rst_n) begin
            mvalid = 1; m_lk = 0; m_terr = 0; m_last = 1; m_cnt = 0;
            e_rv = '0; e_re = '0; e_rd = 0;
        end else if (mvalid) begin
            logic [1:0] er;
            bit acc, rej, wi;
            int ix;
            logic [7:0] ad;
            er = '0;
            if (m_lk) begin
                if (v[m_own] && !ab[m_own]) er[m_own] = 1'b1;
            end else if (v == 2'b11) er[m_last ^ 1] = 1'b1;
            else er = v;
            chk(req_ready == er, m_lk ? "R4 ready" : "R3 ready", 64'(req_ready), 64'(er));
            acc = |er;
            ix  = er[1] ? 1 : 0;
            wi  = we[ix];
            ad  = ix ? a1 : a0;
            rej = m_lk && acc && wi && (ad != m_laddr);
            chk(mem_en == (acc && !rej), rej ? "R6 mem_en" : "R2 mem_en", 64'(mem_en), 64'(acc && !rej));
            chk(rsp_valid == e_rv, "R2 rsp_valid", 64'(rsp_valid), 64'(e_rv));
            chk(rsp_err == e_re, "R6 rsp_err", 64'(rsp_err), 64'(e_re));
            if (e_rv != 0 && e_rd) chk(rsp_rdata == e_rdata, "R2 rdata", 64'(rsp_rdata), 64'(e_rdata));
            chk(atomic_busy == m_lk, {phase, " busy"}, 64'(atomic_busy), 64'(m_lk));
            chk(lock_timeout_err == m_terr, "R8 err", 64'(lock_timeout_err), 64'(m_terr));
            // Advance.
            e_rv = er;
            e_re = rej ? er : 2'b00;
            e_rd = acc && !wi;
            e_rdata = mmem[ad];
            if (acc && wi && !rej) mmem[ad] = ix ? d1 : d0;
            if (m_lk) begin
                if (acc && wi) m_lk = 0;
                else if (ab[m_own]) m_lk = 0;
                else if (m_cnt == TMO - 1) begin m_lk = 0; m_terr = 1; end
                else m_cnt++;
            end else if (acc && lk[ix] && !wi) begin
                m_lk = 1; m_own = ix; m_laddr = ad; m_cnt = 0;
            end
            if (acc) m_last = ix;
        end
    end

    task automatic cyc(input logic [1:0] vv, input logic [1:0] ww, input logic [1:0] ll,
                       input logic [1:0] bb, input logic [7:0] x0, input logic [7:0] x1,
                       input logic [31:0] y0, input logic [31:0] y1);
        v = vv; we = ww; lk = ll; ab = bb; a0 = x0; a1 = x1; d0 = y0; d1 = y1;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state observed by the model compare.
        phase = "R1"; idle(2);
        // R2: plain writes and reads from each master.
        phase = "R2";
        cyc(2'b01, 2'b01, 0, 0, 8'd5, 0, 32'hA5A5_0001, 0);
        cyc(2'b01, 2'b00, 0, 0, 8'd5, 0, 0, 0);
        cyc(2'b10, 2'b10, 0, 0, 0, 8'd6, 0, 32'hB6B6_0002);
        cyc(2'b10, 2'b00, 0, 0, 0, 8'd6, 0, 0);
        idle(1);
        // R3: both masters contend; grants alternate.
        phase = "R3";
        for (int i = 0; i < 6; i++) cyc(2'b11, 2'b00, 0, 0, 8'(i), 8'(i + 40), 0, 0);
        cyc(2'b10, 2'b00, 0, 0, 0, 8'd7, 0, 0);
        cyc(2'b10, 2'b00, 0, 0, 0, 8'd8, 0, 0);
        cyc(2'b11, 2'b00, 0, 0, 8'd9, 8'd9, 0, 0);
        idle(1);
        // R4/R5: master 0 locks word 10; master 1 tries to write it meanwhile.
        phase = "R4";
        cyc(2'b01, 2'b00, 2'b01, 0, 8'd10, 8'd10, 0, 0);
        cyc(2'b11, 2'b10, 0, 0, 8'd11, 8'd10, 0, 32'hDEAD_0000);
        cyc(2'b10, 2'b10, 0, 0, 0, 8'd10, 0, 32'hDEAD_0000);
        phase = "R5";
        cyc(2'b11, 2'b11, 0, 0, 8'd10, 8'd10, 32'h0000_1111, 32'hDEAD_0000);
        cyc(2'b10, 2'b10, 0, 0, 0, 8'd10, 0, 32'hDEAD_0000);
        cyc(2'b01, 2'b00, 0, 0, 8'd10, 0, 0, 0);
        idle(1);
        // R6: master 1 locks word 12 but closes on word 13.
        phase = "R6";
        cyc(2'b10, 2'b00, 2'b10, 0, 0, 8'd12, 0, 0);
        cyc(2'b11, 2'b11, 0, 0, 8'd12, 8'd13, 32'h2222, 32'h3333);
        cyc(2'b01, 2'b01, 0, 0, 8'd12, 0, 32'h2222, 0);
        cyc(2'b01, 2'b00, 0, 0, 8'd13, 0, 0, 0);
        idle(1);
        // R7: aborts when free and from a non-owner are ignored; owner abort frees.
        phase = "R7";
        cyc(2'b01, 2'b00, 0, 2'b11, 8'd14, 0, 0, 0);
        cyc(2'b01, 2'b00, 2'b01, 0, 8'd15, 0, 0, 0);
        cyc(2'b10, 2'b10, 0, 2'b10, 0, 8'd15, 0, 32'h4444);
        cyc(2'b01, 2'b01, 0, 2'b01, 8'd15, 0, 32'h5555, 0);
        cyc(2'b10, 2'b00, 0, 0, 0, 8'd15, 0, 0);
        idle(1);
        // R8: lock held with no write; rival keeps requesting until the watchdog frees it.
        phase = "R8";
        cyc(2'b01, 2'b00, 2'b01, 0, 8'd20, 0, 0, 0);
        for (int i = 0; i < TMO + 4; i++) cyc(2'b10, 2'b10, 0, 0, 0, 8'd20, 0, 32'h6666);
        idle(2);
        // R9: a write marked locked with no lock open stays an ordinary write.
        phase = "R9";
        cyc(2'b01, 2'b01, 2'b01, 0, 8'd30, 0, 32'h7777, 0);
        cyc(2'b10, 2'b00, 0, 0, 0, 8'd30, 0, 0);
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule